// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers up to sixteen device-side interrupt sources and presents them to a host processor as a single interrupt line plus a small register window. Each source is edge-detected: a rising edge on a source input latches a status bit, and that bit stays set until the host removes it. The host removes bits either one at a time, by writing ones to an acknowledge register, or all at once, by reading a status view that clears itself on read. A second status view can be read without disturbing anything.

A mask register decides which latched bits can reach the interrupt line. The host can write the whole mask, or change individual bits through a set alias and a clear alias that leave the other bits alone. The line is the OR of every status bit whose mask bit is 0, and a configuration input chooses whether the line is active high or active low. The register bus is a plain single-cycle strobe interface. Read data is registered and appears in the cycle after the read strobe.

Bit meanings are fixed by convention: 0 receive buffer 0 data, 1 transmit data, 2 transmit transfer, 3 receive buffer 1 data, 4 receive transfer, 5 and 6 event mailbox, 7 wake, 8 and 9 debug trace, 10 command complete, 14 initialisation complete. Bits 11 to 13 and 15 are spare sources that behave the same way.

Top module: `hint_status_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001 (only source 0 blocked), both status views read 0, and the interrupt line is inactive.
- R2: A 0-to-1 change on `src_i[n]` sets status bit n one clock later. A source held high sets the bit only once, so after it is acknowledged the bit stays 0 while the source remains high.
- R3: A read at address 3 (peek view) returns the status bits and leaves them unchanged.
- R4: A read at address 4 (take view) returns the status bits as they were before that clock edge and clears all of them at that edge.
- R5: A write at address 5 (acknowledge) clears every status bit written as 1. Bits written as 0 keep their value.
- R6: When a source rising edge and a clear (acknowledge or take read) of the same bit fall in the same cycle, the bit ends up set.
- R7: A write at address 0 loads the whole mask with the written value.
- R8: A write at address 1 (mask set alias) sets each mask bit written as 1. The other mask bits keep their value.
- R9: A write at address 2 (mask clear alias) clears each mask bit written as 1. The other mask bits keep their value.
- R10: `irq_o` is asserted when any status bit has its mask bit at 0. It is driven 1 when asserted if `irq_act_high_i` is 1, and driven 0 when asserted if `irq_act_high_i` is 0. Otherwise it takes the opposite level.
- R11: Reads at addresses 1, 2, 5, 6 and 7 return 0. Writes at addresses 3 and 4 change neither the mask nor the status.
- R12: A read at address 0 returns the current mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source levels, edge-detected |
| irq_act_high_i | input | 1 | 1: interrupt line active high, 0: active low |
| bus_addr_i | input | 3 | Register word address |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_rdata_o | output | NUM_SRC | Read data, valid the cycle after `bus_rd_i` |
| irq_o | output | 1 | Host interrupt line |

## Verification
The hardest case to reach is a collision: a new source edge landing in the same clock as a clear of that same bit. The clear can come either from an acknowledge write or from a take-view read. The bench reaches this by driving the source change and the bus strobe on the same falling edge, so that both are seen by one rising edge. It then checks through the peek view that the bit survived. In the take-read case it also checks that the returned data did not yet contain the new bit. A source held high across an acknowledge is also exercised, which shows that a level cannot set a status bit a second time.

// File: rtl/hint_pkg.sv
// Package: shared address map and widths for the host interrupt status block.
// Assumes word addressing on a 3-bit register bus.
package hint_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK      = 3'd0,  // read/write mask
        A_MASK_SET  = 3'd1,  // write-only: set mask bits
        A_MASK_CLR  = 3'd2,  // write-only: clear mask bits
        A_STAT_PEEK = 3'd3,  // read-only: status, no side effect
        A_STAT_TAKE = 3'd4,  // read-only: status, cleared by the read
        A_ACK       = 3'd5,  // write-only: write 1 to clear status
        A_SPARE6    = 3'd6,
        A_SPARE7    = 3'd7
    } hint_addr_e;

    // Decoded single-cycle bus actions.
    typedef struct packed {
        logic mask_load;
        logic mask_set;
        logic mask_clr;
        logic ack;
        logic take;
    } hint_act_t;

endpackage

// File: rtl/hint_edge_detect.sv
// Module: hint_edge_detect
// Rising-edge detector for each source input. Sources are assumed to be
// already synchronous to clk. The previous level resets to 0, so a source
// that is high when reset is released counts as one edge.
module hint_edge_detect #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);

    logic [NUM_SRC-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_bit
            // Remember last level of this source.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q[g] <= 1'b0;
                else        prev_q[g] <= src_i[g];
            end
            // An edge is a high level that was low one cycle ago.
            assign rise_o[g] = src_i[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/hint_mask_reg.sv
// Module: hint_mask_reg
// Mask register with a full load and separate bitwise set and clear ports.
// Assumes at most one of the three write strobes is active in a cycle;
// if several are, load beats set, which beats clear.
module hint_mask_reg #(
    parameter int               NUM_SRC   = 16,
    parameter logic [NUM_SRC-1:0] RESET_VAL = NUM_SRC'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               set_i,
    input  logic               clr_i,
    input  logic [NUM_SRC-1:0] data_i,
    output logic [NUM_SRC-1:0] mask_o
);

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_d;

    // Next mask value from the active write strobe.
    always_comb begin
        mask_d = mask_q;
        if (load_i)      mask_d = data_i;
        else if (set_i)  mask_d = mask_q | data_i;
        else if (clr_i)  mask_d = mask_q & ~data_i;
    end

    // Hold the mask; reset blocks only the lowest source.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= RESET_VAL;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/hint_status_reg.sv
// Module: hint_status_reg
// Sticky status bits. A rising edge sets a bit; an acknowledge bit or a
// take-read clears it. When a set and a clear meet in one cycle the set
// wins, so that no event is lost.
module hint_status_reg #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               ack_i,
    input  logic [NUM_SRC-1:0] ack_bits_i,
    input  logic               take_i,
    output logic [NUM_SRC-1:0] status_o
);

    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] clr_vec;

    // Bits cleared this cycle, from either clear path.
    always_comb begin
        clr_vec = '0;
        if (ack_i)  clr_vec = clr_vec | ack_bits_i;
        if (take_i) clr_vec = '1;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_bit
            // Per-bit sticky flag with set priority.
            always_ff @(posedge clk) begin
                if (!rst_n)          stat_q[g] <= 1'b0;
                else if (rise_i[g])  stat_q[g] <= 1'b1;
                else if (clr_vec[g]) stat_q[g] <= 1'b0;
            end
        end
    endgenerate

    assign status_o = stat_q;

endmodule

// File: rtl/hint_bus_port.sv
// Module: hint_bus_port
// Register bus front end: decodes write strobes into actions and holds
// registered read data. Read data is valid in the cycle after the strobe
// and is 0 for write-only and unused addresses.
module hint_bus_port #(
    parameter int NUM_SRC = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [hint_pkg::ADDR_W-1:0] addr_i,
    input  logic                      wr_i,
    input  logic                      rd_i,
    input  logic [NUM_SRC-1:0]        mask_i,
    input  logic [NUM_SRC-1:0]        status_i,
    output hint_pkg::hint_act_t       act_o,
    output logic [NUM_SRC-1:0]        rdata_o
);
    import hint_pkg::*;

    hint_addr_e         addr_e;
    logic [NUM_SRC-1:0] rd_mux;
    logic [NUM_SRC-1:0] rdata_q;

    assign addr_e = hint_addr_e'(addr_i);

    // Turn a strobe plus address into one action.
    always_comb begin
        act_o = '0;
        if (wr_i) begin
            case (addr_e)
                A_MASK:     act_o.mask_load = 1'b1;
                A_MASK_SET: act_o.mask_set  = 1'b1;
                A_MASK_CLR: act_o.mask_clr  = 1'b1;
                A_ACK:      act_o.ack       = 1'b1;
                default:    ;
            endcase
        end
        if (rd_i && addr_e == A_STAT_TAKE) act_o.take = 1'b1;
    end

    // Select read data for the addressed register.
    always_comb begin
        case (addr_e)
            A_MASK:      rd_mux = mask_i;
            A_STAT_PEEK: rd_mux = status_i;
            A_STAT_TAKE: rd_mux = status_i;
            default:     rd_mux = '0;
        endcase
    end

    // Capture read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/hint_status_ctrl.sv
// Module: hint_status_ctrl (top)
// Host interrupt status controller: edge-latched sources, mask with
// set/clear aliases, peek and take status views, write-1 acknowledge and
// one interrupt line of selectable polarity. Sources and bus are assumed
// synchronous to clk.
module hint_status_ctrl #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               irq_act_high_i,
    input  logic [2:0]         bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    input  logic               bus_rd_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               irq_o
);
    import hint_pkg::*;

    logic [NUM_SRC-1:0] rise_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] status_w;
    hint_act_t          act_w;
    logic               pending_w;

    hint_edge_detect #(.NUM_SRC(NUM_SRC)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise_w)
    );

    hint_bus_port #(.NUM_SRC(NUM_SRC)) bus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .mask_i   (mask_w),
        .status_i (status_w),
        .act_o    (act_w),
        .rdata_o  (bus_rdata_o)
    );

    hint_mask_reg #(.NUM_SRC(NUM_SRC), .RESET_VAL(NUM_SRC'(1))) mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (act_w.mask_load),
        .set_i  (act_w.mask_set),
        .clr_i  (act_w.mask_clr),
        .data_i (bus_wdata_i),
        .mask_o (mask_w)
    );

    hint_status_reg #(.NUM_SRC(NUM_SRC)) stat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise_w),
        .ack_i      (act_w.ack),
        .ack_bits_i (bus_wdata_i),
        .take_i     (act_w.take),
        .status_o   (status_w)
    );

    // Any unmasked status bit raises the line.
    assign pending_w = |(status_w & ~mask_w);
    // Apply the configured polarity.
    assign irq_o = irq_act_high_i ? pending_w : ~pending_w;

endmodule

// File: rtl/hint_status_ctrl_chk.sv
// Module: hint_status_ctrl_chk
// Property checker for hint_status_ctrl, bound to every instance.
module hint_status_ctrl_chk #(
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         bus_addr_i,
    input logic               bus_wr_i,
    input logic [NUM_SRC-1:0] bus_wdata_i,
    input logic               bus_rd_i,
    input logic [NUM_SRC-1:0] bus_rdata_o,
    input logic               irq_act_high_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] rise
);

    a_r1_mask_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == NUM_SRC'(1) && status_q == '0));

    a_r3_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 3'd3 && !bus_wr_i && rise == '0)
        |=> (status_q == $past(status_q)));

    a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 3'd4 && rise == '0) |=> (status_q == '0));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 3'd5 && rise == '0)
        |=> ((status_q & $past(bus_wdata_i)) == '0));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));

    a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 3'd1)
        |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    a_r9_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 3'd2) |=> ((mask_q & $past(bus_wdata_i)) == '0));

    a_r10_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> (irq_o == !irq_act_high_i));

    a_r11_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && (bus_addr_i == 3'd1 || bus_addr_i == 3'd2 || bus_addr_i >= 3'd5))
        |=> (bus_rdata_o == '0));

endmodule

bind hint_status_ctrl hint_status_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr_i     (bus_addr_i),
    .bus_wr_i       (bus_wr_i),
    .bus_wdata_i    (bus_wdata_i),
    .bus_rd_i       (bus_rd_i),
    .bus_rdata_o    (bus_rdata_o),
    .irq_act_high_i (irq_act_high_i),
    .irq_o          (irq_o),
    .status_q       (status_w),
    .mask_q         (mask_w),
    .rise           (rise_w)
);

// File: tb/hint_status_ctrl_tb_top.sv
// Bench for hint_status_ctrl: a vector table walked by one loop, then
// directed tests for polarity, collisions and held sources.
module hint_status_ctrl_tb_top;

    localparam int N = 16;
    localparam int K_WR  = 0;
    localparam int K_RD  = 1;
    localparam int K_SRC = 2;

    // entry: kind[41:40] addr[39:37] data[36:21] exp[20:5] req[4:0]
    function automatic logic [41:0] mk(int k, int a, int d, int e, int r);
        return {2'(k), 3'(a), 16'(d), 16'(e), 5'(r)};
    endfunction

    localparam int NV = 26;
    localparam logic [41:0] VECS [0:NV-1] = '{
        mk(K_RD,  0, 0,      16'h0001, 1),   // R1 mask reset
        mk(K_RD,  3, 0,      16'h0000, 1),   // R1 status reset
        mk(K_SRC, 0, 16'h0402, 0,      2),   // R2 edges on 1 and 10
        mk(K_RD,  3, 0,      16'h0402, 2),   // R2 latched
        mk(K_RD,  3, 0,      16'h0402, 3),   // R3 peek unchanged
        mk(K_WR,  5, 16'h0002, 0,      5),
        mk(K_RD,  3, 0,      16'h0400, 5),   // R5 ack bit 1
        mk(K_WR,  5, 16'h0000, 0,      5),
        mk(K_RD,  3, 0,      16'h0400, 5),   // R5 zero ack no effect
        mk(K_WR,  0, 16'h00F0, 0,      7),
        mk(K_RD,  0, 0,      16'h00F0, 12),  // R7 R12 load and read
        mk(K_WR,  1, 16'h0003, 0,      8),
        mk(K_RD,  0, 0,      16'h00F3, 8),   // R8 set alias
        mk(K_WR,  2, 16'h0081, 0,      9),
        mk(K_RD,  0, 0,      16'h0072, 9),   // R9 clear alias
        mk(K_RD,  1, 0,      16'h0000, 11),  // R11 write-only read
        mk(K_RD,  2, 0,      16'h0000, 11),
        mk(K_RD,  5, 0,      16'h0000, 11),
        mk(K_SRC, 0, 16'h8001, 0,      2),
        mk(K_RD,  4, 0,      16'h8401, 4),   // R4 take returns
        mk(K_RD,  3, 0,      16'h0000, 4),   // R4 then cleared
        mk(K_SRC, 0, 16'h0010, 0,      2),
        mk(K_WR,  3, 16'hFFFF, 0,      11),
        mk(K_WR,  4, 16'h0000, 0,      11),
        mk(K_RD,  3, 0,      16'h0010, 11),  // R11 writes to views ignored
        mk(K_RD,  0, 0,      16'h0072, 11)
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         act_high = 1'b1;
    logic [2:0]   addr = '0;
    logic         wr = 1'b0;
    logic [N-1:0] wdata = '0;
    logic         rd = 1'b0;
    logic [N-1:0] rdata;
    logic         irq;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hint_status_ctrl #(.NUM_SRC(N)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_i          (src),
        .irq_act_high_i (act_high),
        .bus_addr_i     (addr),
        .bus_wr_i       (wr),
        .bus_wdata_i    (wdata),
        .bus_rd_i       (rd),
        .bus_rdata_o    (rdata),
        .irq_o          (irq)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(int a, logic [N-1:0] d);
        @(negedge clk); addr = 3'(a); wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(int a, output logic [N-1:0] d);
        @(negedge clk); addr = 3'(a); rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic pulse_src(logic [N-1:0] p);
        @(negedge clk); src = p;
        @(negedge clk); src = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [N-1:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq idle", N'(irq), N'(0));

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", int'(v[4:0]), i);
            case (int'(v[41:40]))
                K_WR:  bus_write(int'(v[39:37]), v[36:21]);
                K_SRC: pulse_src(v[36:21]);
                default: begin
                    bus_read(int'(v[39:37]), got);
                    check(tag, got, v[20:5]);
                end
            endcase
        end

        // R10: status 0x0010 is masked by 0x0072
        check("R10 masked line", N'(irq), N'(0));
        bus_write(2, 16'h0010);
        check("R10 unmasked active high", N'(irq), N'(1));
        act_high = 1'b0; #1;
        check("R10 active low", N'(irq), N'(0));
        act_high = 1'b1;
        bus_write(5, 16'hFFFF);
        check("R10 line after ack", N'(irq), N'(0));

        // R6: edge on bit 5 meets ack of bit 5
        @(negedge clk); src = 16'h0020; addr = 3'd5; wdata = 16'h0020; wr = 1'b1;
        @(negedge clk); src = '0; wr = 1'b0; wdata = '0;
        bus_read(3, got);
        check("R6 set beats ack", got, 16'h0020);
        bus_write(5, 16'hFFFF);

        // R6: edge on bit 7 meets take read
        @(negedge clk); src = 16'h0080; addr = 3'd4; rd = 1'b1;
        @(negedge clk); src = '0; rd = 1'b0; got = rdata;
        check("R6 take returns old", got, 16'h0000);
        bus_read(3, got);
        check("R6 set beats take", got, 16'h0080);
        bus_write(5, 16'hFFFF);

        // R2: held level sets once only
        @(negedge clk); src = 16'h0008;
        @(negedge clk);
        bus_write(5, 16'h0008);
        repeat (3) @(negedge clk);
        bus_read(3, got);
        check("R2 held source no re-set", got, 16'h0000);
        src = '0;

        // R11: unused address reads 0
        bus_read(6, got);
        check("R11 unused address", got, 16'h0000);

        // R1: reset again restores mask
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(0, got);
        check("R1 mask after second reset", got, 16'h0001);

        finish_run();
    end

endmodule